// File: doc/BRIEF.md
# Countdown Timer Run/Stop Controller

This block decides when a minutes-and-seconds countdown chain runs. It holds one run/stop state bit and derives every control the chain needs from it. While stopped, it steers the minute digits to follow the preset switches and holds the seconds at zero. While running, it lets the 1 Hz tick reach the counters, blocks the preset switches and energises the output relay.

A run begins only on a fresh press of the start button, and only when the counter chain reports a non-zero time. Once running, the state holds whether or not the button is still pressed. It ends when the chain raises its timeout flag. The stop state then reloads the preset minutes and clears the seconds in the same cycle. The power-on reset always leaves the block stopped.

The start input is assumed to be already synchronised to the clock. The timeout flag is high whenever the counter chain reads 00:00.

Top module: `cdt_runctl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, the block is stopped: `run_o`=0, `tick_en_o`=0, `relay_o`=0, `load_min_o`=1, `clear_sec_o`=1. This holds even if `start_i` is high during reset.
- R2: In stop, a rising edge of `start_i` with `timeout_i` low enters run. A rising edge means `start_i` is 1 in this cycle and was 0 in the previous cycle. `run_o` is 1 after the next clock edge.
- R3: In stop, a rising edge of `start_i` while `timeout_i` is high (setting 00:00) leaves the block stopped.
- R4: In run, while `timeout_i` is low, the block stays in run whatever `start_i` does, including release and re-press.
- R5: In run, `timeout_i` high returns the block to stop after the next clock edge.
- R6: `load_min_o` and `clear_sec_o` are 1 exactly when the block is stopped, and 0 in run.
- R7: `tick_en_o` is 1 exactly in run.
- R8: `relay_o` is 1 exactly in run.
- R9: In stop, a `start_i` held high without a new rising edge does not start the block. This covers a button held through timeout or through reset.
- R10: In run, a cycle with both `timeout_i` high and a rising edge of `start_i` goes to stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| start_i | input | 1 | Start button, synchronised, active high |
| timeout_i | input | 1 | Counter chain reads 00:00 |
| run_o | output | 1 | Run state |
| tick_en_o | output | 1 | Gate enable for the 1 Hz tick |
| load_min_o | output | 1 | Minute counters take the switch setting |
| clear_sec_o | output | 1 | Seconds counters held at zero |
| relay_o | output | 1 | Output relay enable |

## Verification
The bench applies every sequence of five (start, timeout) input pairs after a reset, with start both high and low during that reset. It compares all five outputs after every edge with a two-bit arithmetic model. The sweep covers several cases that the outputs alone would not separate:
- A press against a 00:00 setting, which must be refused.
- A button held from one cycle into the next, which needs a fresh edge to start.
- A button released or re-pressed during run, which must not stop the timer.
- A timeout that coincides with a press, which must end in stop.

// File: rtl/cdt_runctl.sv
module cdt_runctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic timeout_i,
  output logic run_o,
  output logic tick_en_o,
  output logic load_min_o,
  output logic clear_sec_o,
  output logic relay_o
);

  logic run_q;
  logic start_q;
  logic start_rise;
  logic run_d;

  assign start_rise = start_i & ~start_q;

  always_comb begin
    if (run_q) run_d = ~timeout_i;
    else       run_d = start_rise & ~timeout_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      start_q <= 1'b1;
    end else begin
      run_q   <= run_d;
      start_q <= start_i;
    end
  end

  assign run_o       = run_q;
  assign tick_en_o   = run_q;
  assign relay_o     = run_q;
  assign load_min_o  = ~run_q;
  assign clear_sec_o = ~run_q;

  // R2
  start_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && start_i && !start_q && !timeout_i) |=> run_q);

  // R3
  zero_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && timeout_i) |=> !run_q);

  // R4
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !timeout_i) |=> run_q);

  // R5
  timeout_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && timeout_i) |=> !run_q);

  // R9
  fresh_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && start_i && $past(start_i)) |=> !run_q);

endmodule

// File: tb/cdt_runctl_tb_top.sv
module cdt_runctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic timeout_i = 1'b0;
  logic run_o, tick_en_o, load_min_o, clear_sec_o, relay_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cdt_runctl dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .timeout_i(timeout_i),
    .run_o(run_o), .tick_en_o(tick_en_o), .load_min_o(load_min_o),
    .clear_sec_o(clear_sec_o), .relay_o(relay_o)
  );

  task automatic chk(input string req, input logic exp_run);
    n_vec++;
    if (run_o !== exp_run || relay_o !== exp_run) begin
      n_bad++;
      $display("FAIL %s/R8 run=%b relay=%b expected %b", req, run_o, relay_o, exp_run);
    end
    if (tick_en_o !== exp_run) begin
      n_bad++;
      $display("FAIL %s/R7 tick_en=%b expected %b", req, tick_en_o, exp_run);
    end
    if (load_min_o !== !exp_run || clear_sec_o !== !exp_run) begin
      n_bad++;
      $display("FAIL %s/R6 load=%b clear=%b expected %b", req, load_min_o, clear_sec_o, !exp_run);
    end
  endtask

  initial begin
    for (int seq = 0; seq < 2048; seq++) begin
      logic m_run, m_prev;
      @(negedge clk);
      rst_n = 1'b0;
      start_i = seq[10];
      timeout_i = 1'b0;
      @(negedge clk);
      chk("R1", 1'b0);
      rst_n = 1'b1;
      m_run = 1'b0;
      m_prev = 1'b1;
      for (int st = 0; st < 5; st++) begin
        logic s, t, rise;
        string tag;
        s = seq[2*st];
        t = seq[2*st+1];
        rise = s & ~m_prev;
        if (!m_run && rise && t)       tag = "R3";
        else if (!m_run && rise)       tag = "R2";
        else if (!m_run && s)          tag = (st == 0) ? "R1" : "R9";
        else if (m_run && t && rise)   tag = "R10";
        else if (m_run && t)           tag = "R5";
        else if (m_run)                tag = "R4";
        else                           tag = "R6";
        m_run = m_run ? ~t : (rise & ~t);
        m_prev = s;
        start_i = s;
        timeout_i = t;
        @(negedge clk);
        chk(tag, m_run);
      end
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog run=%b expected completion", run_o);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule